// File: doc/BRIEF.md
# APIC-ID to Cache Tag Mapper

This block turns an 8-bit processor APIC identifier into a short cache-steering tag. It holds a programmable map of eight entries; entry i decides bit i of the tag. Depending on the entry, a tag bit copies one chosen bit of the APIC ID, copies that bit inverted, or takes a fixed value.

Software loads the map through a write port. A lookup request carries an APIC ID and is accepted on a valid/ready handshake. The tag comes back from a register one cycle later. A single mode input sets how entries are encoded when they are written and how they are read during a lookup. There are three modes. Legacy takes one byte per write. Packed takes five 4-bit fields from one word and returns a narrowed, complemented tag. Extended takes two 32-bit words that together hold eight bytes.

Top module: `tagmap_core`

## Requirements
- R1: After reset, rsp_valid is 0, req_ready is 1, rsp_err is 0, and every map entry is 0, so a legacy lookup returns tag 0 for any APIC ID.
- R2: cfg_mode encodings are 0 = legacy, 1 = packed, 2 = extended, and 3 behaves as legacy. A legacy-mode write stores wr_data[7:0] into the entry selected by wr_addr.
- R3: In legacy evaluation, an entry with bit 7 set copies APIC-ID bit entry[6:0] into its tag bit. An entry with bit 7 clear yields 1 when the entry is nonzero and 0 when it is zero.
- R4: A bit index of 8 or more reads as 0, and any inversion is applied after that. In legacy mode the index is entry[6:0]. In extended mode the index is entry[5:0].
- R5: An extended-mode write fills four entries from one 32-bit word: entries 0-3 when wr_addr[0]=0, entries 4-7 when wr_addr[0]=1. Byte k of the word goes to the k-th entry of that group, and each stored byte is masked with 0xDF.
- R6: In extended evaluation, an entry with bit 6 set copies APIC-ID bit entry[5:0]. Otherwise an entry with bit 7 set yields the complement of that bit. Otherwise the tag bit is entry bit 0.
- R7: A packed-mode write reads 4-bit field i from wr_data[4i+3:4i] for i = 0..4. A field value v below 8 stores entry 0x80|v, and a value of 8 or more stores 0. Entries 5-7 are cleared, and wr_data[31:20] is ignored.
- R8: In packed evaluation, the tag is the legacy-rule result complemented, keeping only bits 4:0, with bits 7:5 zero.
- R9: A packed lookup is accepted only if entries 0..4 hold 0x80, 0x00, 0x81, 0x82, 0x82. If they do not, the response has rsp_err=1 and rsp_tag=0. Lookups in the other modes always return rsp_err=0.
- R10: A request accepted (req_valid and req_ready high) at one clock edge produces rsp_valid with its tag after that edge. Without a new accept, rsp_valid drops after a cycle in which rsp_ready is high.
- R11: A map write in the same cycle as an accepted lookup does not affect that lookup. It does take effect for the next lookup.
- R12: While rsp_valid is 1 and rsp_ready is 0, the response stays stable, req_ready is 0, and new requests are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Entry encoding for writes and lookups |
| wr_en | input | 1 | Map write strobe |
| wr_addr | input | 3 | Entry index (legacy) or word select (extended, bit 0) |
| wr_data | input | 32 | Map write data |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_apic | input | 8 | APIC ID to translate |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer accepts response |
| rsp_tag | output | 8 | Resulting cache tag |
| rsp_err | output | 1 | Packed map failed its pattern check |

## Verification
A map write and a lookup can arrive in the same cycle. The bench provokes this by raising wr_en and req_valid together, with the write changing an entry that the lookup depends on. The response is judged against the tag computed from the map before the write. A second lookup afterwards must reflect the new entry. Random traffic also overlaps writes with requests in every mode, and each response is compared with the bench's reference map as it stood before the coinciding write.

// File: rtl/tagmap_pkg.sv
package tagmap_pkg;

  typedef enum logic [1:0] {
    TM_LEGACY   = 2'd0,
    TM_PACKED   = 2'd1,
    TM_EXTENDED = 2'd2,
    TM_ALIAS    = 2'd3
  } tm_mode_e;

  // Required contents of the first five entries for a packed map to be usable
  function automatic logic [7:0] pk_expect(input int unsigned idx);
    case (idx)
      0:       pk_expect = 8'h80;
      1:       pk_expect = 8'h00;
      2:       pk_expect = 8'h81;
      3:       pk_expect = 8'h82;
      default: pk_expect = 8'h82;
    endcase
  endfunction

endpackage

// File: rtl/tagmap_store.sv
module tagmap_store
  import tagmap_pkg::*;
#(
  parameter int N_ENT     = 8,
  parameter int ENT_W     = 8,
  parameter int WORD_W    = 32,
  parameter int PK_FIELDS = 5,
  parameter int ADDR_W    = $clog2(N_ENT)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  tm_mode_e                wr_mode,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [WORD_W-1:0]       wr_data,
  output logic [N_ENT*ENT_W-1:0]  map_flat,
  output logic                    map_ok
);

  localparam int BPW     = WORD_W / ENT_W;
  localparam int N_WORDS = (N_ENT + BPW - 1) / BPW;
  localparam int WSEL_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int NIB_W   = 4;
  localparam logic [ENT_W-1:0] VALID_BIT = ENT_W'(1) << (ENT_W - 1);
  localparam logic [ENT_W-1:0] EXT_MASK  = ~(ENT_W'(1) << (ENT_W - 3));

  logic [ENT_W-1:0] map_q   [N_ENT];
  logic [ENT_W-1:0] map_nxt [N_ENT];
  logic [WSEL_W-1:0] wsel;

  assign wsel = WSEL_W'(wr_addr);

  // Next-state decode per encoding
  always_comb begin
    logic [NIB_W-1:0] nib;
    nib = '0;
    for (int e = 0; e < N_ENT; e++) map_nxt[e] = map_q[e];
    case (wr_mode)
      TM_PACKED: begin
        for (int e = 0; e < N_ENT; e++) begin
          if (e < PK_FIELDS) begin
            nib = wr_data[e*NIB_W +: NIB_W];
            map_nxt[e] = nib[NIB_W-1] ? '0 : (VALID_BIT | ENT_W'(nib[NIB_W-2:0]));
          end else begin
            map_nxt[e] = '0;
          end
        end
      end
      TM_EXTENDED: begin
        for (int e = 0; e < N_ENT; e++) begin
          if ((e / BPW) == int'(wsel))
            map_nxt[e] = wr_data[(e % BPW)*ENT_W +: ENT_W] & EXT_MASK;
        end
      end
      default: begin
        map_nxt[wr_addr] = wr_data[ENT_W-1:0];
      end
    endcase
  end

  // Map registers with explicit write enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) map_q[e] <= '0;
    end else if (wr_en) begin
      for (int e = 0; e < N_ENT; e++) map_q[e] <= map_nxt[e];
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_flat
    assign map_flat[g*ENT_W +: ENT_W] = map_q[g];
  end

  // Packed pattern check on the stored map
  always_comb begin
    map_ok = 1'b1;
    for (int e = 0; e < PK_FIELDS; e++)
      if (map_q[e] != ENT_W'(pk_expect(e))) map_ok = 1'b0;
  end

  logic upper_any;
  always_comb begin
    upper_any = 1'b0;
    for (int e = PK_FIELDS; e < N_ENT; e++) upper_any = upper_any | (|map_q[e]);
  end

  // R7: a packed load leaves entries beyond the field count empty
  p_packed_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode == TM_PACKED) |=> !upper_any);

  // R2: a legacy byte write lands in the addressed entry
  p_legacy_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_mode == TM_LEGACY || wr_mode == TM_ALIAS))
      |=> map_q[$past(wr_addr)] == $past(wr_data[ENT_W-1:0]));

  // R5: an extended write never leaves bit 5 set in the first entry of its group
  p_ext_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode == TM_EXTENDED)
      |=> map_q[int'($past(wsel)) * BPW][ENT_W-3] == 1'b0);

endmodule

// File: rtl/tagmap_eval.sv
module tagmap_eval #(
  parameter int N_ENT  = 8,
  parameter int ENT_W  = 8,
  parameter int APIC_W = 8
) (
  input  logic [N_ENT*ENT_W-1:0] map_flat,
  input  logic [APIC_W-1:0]      apic,
  output logic [N_ENT-1:0]       leg_bits,
  output logic [N_ENT-1:0]       ext_bits
);

  localparam int IDX_W = ENT_W - 1;

  // Out-of-range indices read as zero
  function automatic logic pick(input logic [APIC_W-1:0] a, input logic [IDX_W-1:0] idx);
    pick = 1'b0;
    for (int k = 0; k < APIC_W; k++)
      if (idx == IDX_W'(k)) pick = a[k];
  endfunction

  for (genvar g = 0; g < N_ENT; g++) begin : g_bit
    logic [ENT_W-1:0] ent;
    logic             leg_pick;
    logic             ext_pick;

    assign ent      = map_flat[g*ENT_W +: ENT_W];
    assign leg_pick = pick(apic, ent[IDX_W-1:0]);
    assign ext_pick = pick(apic, {1'b0, ent[ENT_W-3:0]});

    assign leg_bits[g] = ent[ENT_W-1] ? leg_pick : (|ent);
    assign ext_bits[g] = ent[ENT_W-2] ? ext_pick
                       : ent[ENT_W-1] ? ~ext_pick
                       : ent[0];
  end

endmodule

// File: rtl/tagmap_core.sv
module tagmap_core
  import tagmap_pkg::*;
#(
  parameter int N_ENT     = 8,
  parameter int ENT_W     = 8,
  parameter int APIC_W    = 8,
  parameter int WORD_W    = 32,
  parameter int PK_FIELDS = 5,
  parameter int PK_W      = 5,
  parameter int ADDR_W    = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [APIC_W-1:0] req_apic,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [N_ENT-1:0]  rsp_tag,
  output logic              rsp_err
);

  tm_mode_e mode;
  assign mode = tm_mode_e'(cfg_mode);

  logic [N_ENT*ENT_W-1:0] map_flat;
  logic                   map_ok;
  logic [N_ENT-1:0]       leg_bits;
  logic [N_ENT-1:0]       ext_bits;

  tagmap_store #(
    .N_ENT(N_ENT), .ENT_W(ENT_W), .WORD_W(WORD_W),
    .PK_FIELDS(PK_FIELDS), .ADDR_W(ADDR_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(mode),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .map_flat(map_flat), .map_ok(map_ok)
  );

  tagmap_eval #(
    .N_ENT(N_ENT), .ENT_W(ENT_W), .APIC_W(APIC_W)
  ) eval_i (
    .map_flat(map_flat), .apic(req_apic),
    .leg_bits(leg_bits), .ext_bits(ext_bits)
  );

  logic             vld_q, vld_nxt;
  logic [N_ENT-1:0] tag_q, tag_nxt;
  logic             err_q, err_nxt;
  logic             pk_q, pk_nxt;
  logic             accept;

  assign req_ready = !vld_q || rsp_ready;
  assign accept    = req_valid && req_ready;

  // Next-state for the response stage
  always_comb begin
    tag_nxt = leg_bits;
    err_nxt = 1'b0;
    pk_nxt  = 1'b0;
    case (mode)
      TM_PACKED: begin
        pk_nxt = 1'b1;
        if (map_ok) begin
          tag_nxt = {{(N_ENT-PK_W){1'b0}}, ~leg_bits[PK_W-1:0]};
        end else begin
          tag_nxt = '0;
          err_nxt = 1'b1;
        end
      end
      TM_EXTENDED: tag_nxt = ext_bits;
      default:     tag_nxt = leg_bits;
    endcase
    if (accept)         vld_nxt = 1'b1;
    else if (rsp_ready) vld_nxt = 1'b0;
    else                vld_nxt = vld_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      tag_q <= '0;
      err_q <= 1'b0;
      pk_q  <= 1'b0;
    end else begin
      vld_q <= vld_nxt;
      if (accept) begin
        tag_q <= tag_nxt;
        err_q <= err_nxt;
        pk_q  <= pk_nxt;
      end
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_tag   = tag_q;
  assign rsp_err   = err_q;

  // R10: an accepted request yields a valid response on the next cycle
  p_accept_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R12: a stalled response holds its contents
  p_hold_rsp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tag) && $stable(rsp_err)));

  // R12: no new request is taken while a response is stalled
  p_no_accept_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R9: a rejected packed map gives an all-zero tag
  p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_tag == '0));

  // R8: packed responses use only the narrow tag width
  p_packed_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && pk_q) |-> (rsp_tag[N_ENT-1:PK_W] == '0));

  // R9: errors are only reported for packed lookups
  p_err_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> pk_q);

endmodule

// File: tb/tagmap_core_tb.sv
`timescale 1ns/1ps
module tagmap_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_mode;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_apic;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [7:0]  rsp_tag;
  logic        rsp_err;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [7:0] bm [8];

  always #2 clk = ~clk;

  tagmap_core dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .req_valid(req_valid),
    .req_ready(req_ready), .req_apic(req_apic), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_tag(rsp_tag), .rsp_err(rsp_err)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic bpick(input logic [7:0] a, input int idx);
    return (idx < 8) ? a[idx] : 1'b0;
  endfunction

  function automatic logic [7:0] leg_tag(input logic [7:0] a);
    logic [7:0] t;
    for (int i = 0; i < 8; i++)
      t[i] = bm[i][7] ? bpick(a, int'(bm[i][6:0])) : (bm[i] != 0);
    return t;
  endfunction

  // returns {err, tag}
  function automatic logic [8:0] model(input logic [1:0] m, input logic [7:0] a);
    logic [7:0] t;
    logic ok;
    case (m)
      2'd1: begin
        ok = (bm[0] == 8'h80) && (bm[1] == 8'h00) && (bm[2] == 8'h81) &&
             (bm[3] == 8'h82) && (bm[4] == 8'h82);
        if (!ok) return {1'b1, 8'h00};
        t = leg_tag(a);
        return {1'b0, 3'b000, ~t[4:0]};
      end
      2'd2: begin
        for (int i = 0; i < 8; i++) begin
          if (bm[i][6])      t[i] = bpick(a, int'(bm[i][5:0]));
          else if (bm[i][7]) t[i] = ~bpick(a, int'(bm[i][5:0]));
          else               t[i] = bm[i][0];
        end
        return {1'b0, t};
      end
      default: return {1'b0, leg_tag(a)};
    endcase
  endfunction

  task automatic model_write(input logic [1:0] m, input logic [2:0] ad, input logic [31:0] d);
    case (m)
      2'd1: for (int e = 0; e < 8; e++)
              bm[e] = (e < 5 && d[e*4+3] == 1'b0) ? (8'h80 | {5'b0, d[e*4 +: 3]}) : 8'h00;
      2'd2: for (int b = 0; b < 4; b++)
              bm[ad[0]*4 + b] = d[b*8 +: 8] & 8'hDF;
      default: bm[ad] = d[7:0];
    endcase
  endtask

  task automatic do_write(input logic [1:0] m, input logic [2:0] ad, input logic [31:0] d);
    @(negedge clk);
    cfg_mode = m; wr_en = 1'b1; wr_addr = ad; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(m, ad, d);
  endtask

  task automatic do_lookup(input string req, input logic [1:0] m, input logic [7:0] a);
    logic [8:0] e;
    @(negedge clk);
    cfg_mode = m; req_apic = a; req_valid = 1'b1;
    e = model(m, a);
    @(negedge clk);
    req_valid = 1'b0;
    check(req, "rsp_valid", {31'b0, rsp_valid}, 32'd1);
    check(req, "rsp_tag",   {24'b0, rsp_tag},   {24'b0, e[7:0]});
    check(req, "rsp_err",   {31'b0, rsp_err},   {31'b0, e[8]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [8:0] ea, eb;
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    for (int i = 0; i < 8; i++) bm[i] = 8'h00;
    rst_n = 1'b0; cfg_mode = 2'd0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    req_valid = 1'b0; req_apic = '0; rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "rsp_valid at reset", {31'b0, rsp_valid}, 32'd0);
    check("R1", "req_ready at reset", {31'b0, req_ready}, 32'd1);
    check("R1", "rsp_err at reset",   {31'b0, rsp_err},   32'd0);
    rst_n = 1'b1;
    do_lookup("R1", 2'd0, 8'hFF);

    // R2 R3 R4: legacy entries
    do_write(2'd0, 3'd0, 32'h00000080);
    do_write(2'd0, 3'd1, 32'h00000087);
    do_write(2'd0, 3'd2, 32'h00000000);
    do_write(2'd0, 3'd3, 32'hFFFFFF05);
    do_write(2'd0, 3'd4, 32'h00000088);
    do_write(2'd0, 3'd5, 32'h000000FF);
    do_write(2'd0, 3'd6, 32'h00000083);
    do_write(2'd3, 3'd7, 32'h00000001);
    do_lookup("R3", 2'd0, 8'hFF);
    do_lookup("R3", 2'd0, 8'h00);
    do_lookup("R4", 2'd0, 8'hA5);
    do_lookup("R2", 2'd3, 8'h5A);

    // R10: response drops one cycle after it is consumed
    @(negedge clk);
    check("R10", "rsp_valid idle", {31'b0, rsp_valid}, 32'd0);

    // R5 R6 R4: extended entries
    do_write(2'd2, 3'd0, {8'hC1, 8'h01, 8'h83, 8'h42});
    do_write(2'd2, 3'd1, {8'h00, 8'h8F, 8'h4A, 8'h21});
    do_lookup("R6", 2'd2, 8'h0F);
    do_lookup("R6", 2'd2, 8'hF0);
    do_lookup("R4", 2'd2, 8'h55);
    do_write(2'd2, 3'd0, {8'h00, 8'h00, 8'h00, 8'hA4});
    do_lookup("R5", 2'd2, 8'h10);
    do_lookup("R5", 2'd2, 8'h00);

    // R7 R8 R9: packed loads
    do_write(2'd1, 3'd0, 32'hABC22180);
    do_lookup("R8", 2'd1, 8'h07);
    do_lookup("R8", 2'd1, 8'h02);
    do_lookup("R7", 2'd0, 8'hFF);
    do_lookup("R9", 2'd2, 8'hFF);
    do_write(2'd1, 3'd0, 32'h00022181);
    do_lookup("R9", 2'd1, 8'h07);
    do_lookup("R7", 2'd0, 8'h03);

    // R11: write and lookup in the same cycle
    do_write(2'd0, 3'd0, 32'h00000080);
    @(negedge clk);
    cfg_mode = 2'd0; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h00000000;
    req_valid = 1'b1; req_apic = 8'h01;
    ea = model(2'd0, 8'h01);
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R11", "tag uses old map", {24'b0, rsp_tag}, {24'b0, ea[7:0]});
    model_write(2'd0, 3'd0, 32'h00000000);
    do_lookup("R11", 2'd0, 8'h01);

    // R12: backpressure
    do_write(2'd0, 3'd0, 32'h00000080);
    ea = model(2'd0, 8'h00);
    eb = model(2'd0, 8'hFF);
    @(negedge clk);
    rsp_ready = 1'b0; cfg_mode = 2'd0; req_apic = 8'h00; req_valid = 1'b1;
    @(negedge clk);
    check("R12", "first rsp tag", {24'b0, rsp_tag}, {24'b0, ea[7:0]});
    check("R12", "req_ready stalled", {31'b0, req_ready}, 32'd0);
    req_apic = 8'hFF;
    @(negedge clk);
    check("R12", "held rsp_valid", {31'b0, rsp_valid}, 32'd1);
    check("R12", "held tag", {24'b0, rsp_tag}, {24'b0, ea[7:0]});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12", "second rsp tag", {24'b0, rsp_tag}, {24'b0, eb[7:0]});

    // random mix, including overlapped write and lookup
    for (int it = 0; it < 500; it++) begin
      logic [1:0] m;
      logic [31:0] d;
      logic [2:0] ad;
      logic [7:0] a;
      int op;
      m  = 2'($urandom % 4);
      d  = $urandom;
      ad = 3'($urandom % 8);
      a  = 8'($urandom);
      op = int'($urandom % 4);
      if (m == 2'd1 && ($urandom % 2) == 0) d = {d[31:20], 20'h22180};
      if (op == 0) begin
        do_write(m, ad, d);
      end else if (op == 1) begin
        @(negedge clk);
        cfg_mode = m; wr_en = 1'b1; wr_addr = ad; wr_data = d;
        req_valid = 1'b1; req_apic = a;
        ea = model(m, a);
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R11", "rand overlap tag", {24'b0, rsp_tag}, {24'b0, ea[7:0]});
        check("R11", "rand overlap err", {31'b0, rsp_err}, {31'b0, ea[8]});
        model_write(m, ad, d);
      end else begin
        do_lookup("R10", m, a);
      end
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule